// File: doc/BRIEF.md
# Accumulator ALU with Addressing

This block executes the arithmetic, load/store and logic instruction group of a small 8-bit machine whose 256-byte memory also holds the registers. The registers sit at fixed addresses: A at 0, B at 1 and X at 2. A, B and X each have a flag byte at `FLAG_BASE + n`, where n is the register number. A caller, normally the fetch sequencer, hands over the opcode byte, the second instruction byte and the address that second byte came from, and pulses `start_i`. The block then works through a single-port memory. Reads are combinational and are captured at the clock edge. Writes take effect at the clock edge.

The opcode is split into three fields: P in bits 7:6, Q in bits 4:3 and R in bits 2:0. R selects where the operand comes from. P selects the register. Q selects the operation. The block makes only the memory accesses that the instruction needs, one per cycle. It then pulses `done_o` for one cycle, and the caller advances its program counter by two.

Top module: `acc_alu`

## Requirements
- R1: After reset, `done_o` and `mem_we_o` are low until the next `start_i`.
- R2: For P in 0..2 with Q=0, register P becomes (reg + operand) mod 256. Its flag byte is then written with bit 1 set to the unsigned carry out, bit 0 set to the two's-complement overflow, and all other bits zero.
- R3: For P in 0..2 with Q=1, register P becomes (reg - operand) mod 256. Its flag byte is written with bit 1 set to the borrow (reg < operand unsigned), bit 0 set to the signed overflow, and all other bits zero.
- R4: With Q=2 the operand is loaded into register P. With Q=3 register P is stored to the operand location, and for R=3 that location is the second-byte address `arg_addr_i`. Neither operation writes a flag byte.
- R5: The operand is chosen by R. R=3 uses the second byte itself. R=4 uses mem[second]. R=5 uses mem[mem[second]]. R=6 uses mem[second+X]. R=7 uses mem[mem[second]+X]. Every address sum wraps to 8 bits.
- R6: With P=3, Q=0 ORs the operand into A and Q=2 ANDs the operand into A. No flag byte changes.
- R7: With P=3 and Q=3, A receives the two's-complement negation of the operand. No flag byte changes.
- R8: P=3 with Q=1, and any opcode with R below 3, make no memory write. For these, `done_o` rises one cycle after start.
- R9: `done_o` is a single-cycle pulse. Measured from the start edge, it comes after one cycle per required memory access plus one cycle.
- R10: For add and subtract, the register write comes first and the flag write at `FLAG_BASE + P` comes in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin execution; sampled only while idle |
| opcode_i | input | 8 | Instruction opcode byte |
| arg_i | input | 8 | Second instruction byte |
| arg_addr_i | input | 8 | Memory address of the second byte |
| mem_addr_o | output | 8 | Memory address |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data (combinational) |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A wrong captured pointer, index or operand shows up as a write to the wrong address or with the wrong value, and it appears within the same instruction. An access skipped or taken in error moves the `done_o` pulse by a cycle, so it shows in the latency of that same instruction. A bad flag computation appears only in the flag byte. That byte is written on the last access before `done_o`, so every instruction ends with a check of the whole memory image against a reference.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_PTR  = 3'd1,
    S_X    = 3'd2,
    S_OPND = 3'd3,
    S_REG  = 3'd4,
    S_WR   = 3'd5,
    S_WRF  = 3'd6,
    S_DONE = 3'd7
  } state_e;

  // first state after cur whose need bit is set
  function automatic state_e step_next(state_e cur, logic [7:0] need);
    state_e n = S_DONE;
    for (int i = 7; i >= 1; i--) begin
      if (i > int'(cur) && need[i]) n = state_e'(3'(i));
    end
    return n;
  endfunction
endpackage

// File: rtl/acc_alu_addr.sv
module acc_alu_addr #(
  parameter int AW = 8
) (
  input  logic [2:0]    mode_i,
  input  logic [AW-1:0] arg_i,
  input  logic [AW-1:0] ptr_i,
  input  logic [AW-1:0] x_i,
  output logic [AW-1:0] ea_o
);
  logic [AW-1:0] base;
  assign base = mode_i[0] ? ptr_i : arg_i;
  // modes 6/7 add X, sum wraps
  assign ea_o = mode_i[1] ? base + x_i : base;
endmodule

// File: rtl/acc_alu_exec.sv
module acc_alu_exec #(
  parameter int DW = 8
) (
  input  logic [1:0]    p_i,
  input  logic [1:0]    q_i,
  input  logic [DW-1:0] reg_i,
  input  logic [DW-1:0] opnd_i,
  output logic [DW-1:0] wr_o,
  output logic [DW-1:0] flag_o
);
  logic [DW:0] sum, dif;
  logic        ovf_add, ovf_sub;

  assign sum = {1'b0, reg_i} + {1'b0, opnd_i};
  assign dif = {1'b0, reg_i} - {1'b0, opnd_i};
  assign ovf_add = (reg_i[DW-1] == opnd_i[DW-1]) && (sum[DW-1] != reg_i[DW-1]);
  assign ovf_sub = (reg_i[DW-1] != opnd_i[DW-1]) && (dif[DW-1] != reg_i[DW-1]);

  always_comb begin
    flag_o = '0;
    wr_o   = opnd_i;
    if (p_i != 2'd3) begin
      unique case (q_i)
        2'd0: begin wr_o = sum[DW-1:0]; flag_o[1] = sum[DW]; flag_o[0] = ovf_add; end
        2'd1: begin wr_o = dif[DW-1:0]; flag_o[1] = dif[DW]; flag_o[0] = ovf_sub; end
        2'd2: wr_o = opnd_i;
        default: wr_o = reg_i;
      endcase
    end else begin
      unique case (q_i)
        2'd0: wr_o = reg_i | opnd_i;
        2'd2: wr_o = reg_i & opnd_i;
        2'd3: wr_o = DW'(0) - opnd_i;
        default: wr_o = reg_i;
      endcase
    end
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int          DW         = 8,
  parameter logic [7:0]  FLAG_BASE  = 8'h81,
  parameter logic [7:0]  REG_X_ADDR = 8'h02
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [7:0]    opcode_i,
  input  logic [DW-1:0] arg_i,
  input  logic [DW-1:0] arg_addr_i,
  output logic [DW-1:0] mem_addr_o,
  output logic          mem_we_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          done_o
);
  localparam int AW = DW;

  state_e        state_q, state_d;
  logic [7:0]    op_q, op_cur;
  logic [AW-1:0] arg_q, arg_addr_q;
  logic [DW-1:0] ptr_q, x_q, opnd_q, reg_q, opnd_val;
  logic [AW-1:0] ea;
  logic [DW-1:0] wr_val, flag_val;
  logic [7:0]    need;
  logic [1:0]    p, q, pc, qc;
  logic [2:0]    r, rc;
  logic          valid, is_store;

  assign op_cur = (state_q == S_IDLE) ? opcode_i : op_q;
  assign pc = op_cur[7:6];
  assign qc = op_cur[4:3];
  assign rc = op_cur[2:0];
  assign p  = op_q[7:6];
  assign q  = op_q[4:3];
  assign r  = op_q[2:0];

  assign valid    = (rc >= 3'd3) && !(pc == 2'd3 && qc == 2'd1);
  assign is_store = (pc != 2'd3) && (qc == 2'd3);

  always_comb begin
    need    = '0;
    need[1] = valid && rc[0] && rc[2] && (rc != 3'd4) ? 1'b1 : 1'b0;  // 5,7
    need[1] = valid && (rc == 3'd5 || rc == 3'd7);
    need[2] = valid && (rc == 3'd6 || rc == 3'd7);
    need[3] = valid && (rc >= 3'd4) && !is_store;
    need[4] = valid && ((pc != 2'd3) ? (qc != 2'd2) : (qc != 2'd3));
    need[5] = valid;
    need[6] = valid && (pc != 2'd3) && (qc[1] == 1'b0);
    need[7] = 1'b1;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (start_i) state_d = step_next(S_IDLE, need);
      S_DONE:  state_d = S_IDLE;
      default: state_d = step_next(state_q, need);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      op_q       <= '0;
      arg_q      <= '0;
      arg_addr_q <= '0;
      ptr_q      <= '0;
      x_q        <= '0;
      opnd_q     <= '0;
      reg_q      <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && start_i) begin
        op_q       <= opcode_i;
        arg_q      <= arg_i;
        arg_addr_q <= arg_addr_i;
      end
      if (state_q == S_PTR)  ptr_q  <= mem_rdata_i;
      if (state_q == S_X)    x_q    <= mem_rdata_i;
      if (state_q == S_OPND) opnd_q <= mem_rdata_i;
      if (state_q == S_REG)  reg_q  <= mem_rdata_i;
    end
  end

  acc_alu_addr #(.AW(AW)) i_addr (
    .mode_i (r),
    .arg_i  (arg_q),
    .ptr_i  (ptr_q),
    .x_i    (x_q),
    .ea_o   (ea)
  );

  assign opnd_val = (r == 3'd3) ? arg_q : opnd_q;

  acc_alu_exec #(.DW(DW)) i_exec (
    .p_i    (p),
    .q_i    (q),
    .reg_i  (reg_q),
    .opnd_i (opnd_val),
    .wr_o   (wr_val),
    .flag_o (flag_val)
  );

  logic [AW-1:0] reg_addr;
  assign reg_addr = (p == 2'd3) ? '0 : AW'(p);

  always_comb begin
    mem_addr_o  = '0;
    mem_we_o    = 1'b0;
    mem_wdata_o = wr_val;
    unique case (state_q)
      S_PTR:  mem_addr_o = arg_q;
      S_X:    mem_addr_o = REG_X_ADDR;
      S_OPND: mem_addr_o = ea;
      S_REG:  mem_addr_o = reg_addr;
      S_WR: begin
        mem_we_o   = 1'b1;
        if (p != 2'd3 && q == 2'd3) mem_addr_o = (r == 3'd3) ? arg_addr_q : ea;
        else                        mem_addr_o = reg_addr;
      end
      S_WRF: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = FLAG_BASE + AW'(p);
        mem_wdata_o = flag_val;
      end
      default: ;
    endcase
  end

  assign done_o = (state_q == S_DONE);
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          done_o,
  input logic          mem_we_o,
  input logic [DW-1:0] mem_wdata_o,
  input state_e        state_q
);
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_no_write_at_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !done_o);

  p_flag_after_reg_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_WRF |-> $past(state_q) == S_WR && $past(mem_we_o));

  p_flag_upper_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_WRF |-> mem_wdata_o[DW-1:2] == '0);

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_IDLE |-> !mem_we_o && !done_o);
endmodule

bind acc_alu acc_alu_chk #(.DW(DW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .done_o      (done_o),
  .mem_we_o    (mem_we_o),
  .mem_wdata_o (mem_wdata_o),
  .state_q     (state_q)
);

// File: tb/test_acc_alu.sv
module test_acc_alu;
  localparam logic [7:0] FB = 8'h81;

  logic       clk = 1'b0, rst_ni = 1'b0, start = 1'b0;
  logic [7:0] opcode = '0, arg = '0, arg_addr = '0;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic       mem_we, done;
  logic [7:0] mem [256];
  logic [7:0] ref_mem [256];
  int         n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  acc_alu i_acc_alu (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start), .opcode_i(opcode),
    .arg_i(arg), .arg_addr_i(arg_addr), .mem_addr_o(mem_addr), .mem_we_o(mem_we),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .done_o(done)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  initial begin
    #1_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model on ref_mem; returns expected cycles to done
  function automatic int ref_exec(logic [7:0] op, logic [7:0] a, logic [7:0] aa);
    logic [1:0] p = op[7:6], q = op[4:3];
    logic [2:0] r = op[2:0];
    logic [7:0] ptr, x, ea, opnd, rv, res, fl;
    logic [8:0] w;
    int acc = 0;
    if (r < 3 || (p == 3 && q == 1)) return 1;
    ptr = ref_mem[a]; x = ref_mem[2];
    if (r == 5 || r == 7) acc++;
    if (r == 6 || r == 7) acc++;
    ea = (r == 4) ? a : (r == 5) ? ptr : (r == 6) ? 8'(a + x) : 8'(ptr + x);
    opnd = (r == 3) ? a : ref_mem[ea];
    if (r >= 4 && !(p != 3 && q == 3)) acc++;
    if (p != 3) begin
      rv = ref_mem[p];
      if (q != 2) acc++;
      fl = '0;
      case (q)
        2'd0: begin
          w = {1'b0, rv} + {1'b0, opnd}; res = w[7:0];
          fl[1] = w[8]; fl[0] = (rv[7] == opnd[7]) && (res[7] != rv[7]);
          ref_mem[p] = res; ref_mem[FB + 8'(p)] = fl; acc += 2;
        end
        2'd1: begin
          w = {1'b0, rv} - {1'b0, opnd}; res = w[7:0];
          fl[1] = (rv < opnd); fl[0] = (rv[7] != opnd[7]) && (res[7] != rv[7]);
          ref_mem[p] = res; ref_mem[FB + 8'(p)] = fl; acc += 2;
        end
        2'd2: begin ref_mem[p] = opnd; acc++; end
        default: begin ref_mem[(r == 3) ? aa : ea] = rv; acc++; end
      endcase
    end else begin
      if (q != 3) acc++;
      case (q)
        2'd0: ref_mem[0] = ref_mem[0] | opnd;
        2'd2: ref_mem[0] = ref_mem[0] & opnd;
        default: ref_mem[0] = 8'(0 - opnd);
      endcase
      acc++;
    end
    return acc + 1;
  endfunction

  function automatic string tag_of(logic [7:0] op);
    if (op[2:0] < 3 || op[7:3] == 5'b11001) return "R8";
    if (op[7:6] == 3) return (op[4:3] == 3) ? "R7" : "R6";
    case (op[4:3])
      2'd0: return "R2";
      2'd1: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic run_op(logic [7:0] op, logic [7:0] a, logic [7:0] aa, string tag);
    int exp_cyc, cyc, bad;
    foreach (mem[i]) ref_mem[i] = mem[i];
    exp_cyc = ref_exec(op, a, aa);
    @(negedge clk);
    start = 1'b1; opcode = op; arg = a; arg_addr = aa;
    @(negedge clk);
    start = 1'b0; opcode = $urandom; arg = $urandom;
    cyc = 1;
    while (!done && cyc < 40) begin @(negedge clk); cyc++; end
    check({"R9 latency ", tag}, cyc, exp_cyc);
    bad = -1;
    foreach (mem[i]) if (bad < 0 && mem[i] !== ref_mem[i]) bad = i;
    if (bad >= 0) check({tag, " mem[", $sformatf("%0h", bad), "]"}, mem[bad], ref_mem[bad]);
    else check(tag, 0, 0);
    @(negedge clk);
    check("R9 done pulse width", done, 0);
  endtask

  task automatic fill();
    foreach (mem[i]) mem[i] = 8'($urandom);
  endtask

  initial begin
    void'($urandom(32'd1234));
    fill();
    repeat (3) @(negedge clk);
    check("R1 done after reset", done, 0);
    check("R1 we after reset", mem_we, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 done idle", done, 0);
    check("R1 we idle", mem_we, 0);

    // R2 overflow: 7f + 01 into A, immediate
    fill(); mem[0] = 8'h7f; run_op(8'b00_000_011, 8'h01, 8'h40, "R2");
    check("R2 A value", mem[0], 8'h80); check("R2 A flags", mem[FB], 8'h01);
    // R2 carry on B
    fill(); mem[1] = 8'hff; run_op(8'b01_000_011, 8'h01, 8'h40, "R2");
    check("R2 B flags", mem[FB + 1], 8'h02);
    // R3 borrow, R3 overflow on X
    fill(); mem[2] = 8'h00; run_op(8'b10_001_011, 8'h01, 8'h40, "R3");
    check("R3 X borrow", mem[FB + 2], 8'h02);
    fill(); mem[0] = 8'h80; run_op(8'b00_001_011, 8'h01, 8'h40, "R3");
    check("R3 A overflow", mem[FB], 8'h01);
    // R4 store immediate writes second-byte location
    fill(); mem[1] = 8'h5a; run_op(8'b01_011_011, 8'h77, 8'h33, "R4");
    check("R4 store imm target", mem[8'h33], 8'h5a);
    // R5 indirect-indexed with wrap
    fill(); mem[2] = 8'hf0; mem[8'h20] = 8'h30; mem[8'h20] = 8'h30;
    run_op(8'b00_010_111, 8'h20, 8'h40, "R5");
    check("R5 wrap load", mem[0], mem[8'h20]);
    fill(); mem[2] = 8'h10; mem[8'hf8] = 8'h99;
    run_op(8'b00_010_110, 8'he8, 8'h40, "R5");
    check("R5 indexed load", mem[0], 8'h99);
    // R7 negate 0x80 stays 0x80, flags unchanged
    fill(); mem[8'h50] = 8'h80;
    run_op(8'b11_011_100, 8'h50, 8'h40, "R7");
    check("R7 neg 80", mem[0], 8'h80);
    // R8 no-op variants
    fill(); run_op(8'b11_001_101, 8'h10, 8'h40, "R8");
    fill(); run_op(8'b00_000_010, 8'h10, 8'h40, "R8");
    // R10 flag address per register
    fill(); run_op(8'b10_000_100, 8'h60, 8'h40, "R10");

    for (int k = 0; k < 300; k++) begin
      logic [7:0] op;
      fill();
      op = {2'($urandom), 1'b0, 2'($urandom), 3'($urandom)};
      run_op(op, 8'($urandom), 8'($urandom), tag_of(op));
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule